// File: doc/BRIEF.md
# Bitonic Butterfly Sorting Network

This block sorts a vector of 2^N unsigned words of W bits into non-decreasing order. Every comparison happens in one combinational network, so a new vector can be presented on every clock. The network is built recursively. A full sort of size 2^k first sorts its lower half ascending and its upper half descending. The result is bitonic, and a butterfly merger of order k then finishes the sort.

The merger uses a butterfly connection pattern. An order-k butterfly applies an order-(k-1) interleave of a compare-exchange cell, then runs two independent order-(k-1) butterflies, one on each half of the bus. An interleave of order m takes the bus apart into its even-indexed and odd-indexed words. It applies the order-(m-1) interleave to each group and then merges the two groups back into alternating positions. An order-0 interleave is a single cell, and an order-0 butterfly is a plain pass-through.

Word j of a bus sits in bits [j*W +: W]. Word 0 receives the smallest value. A parameter chooses between a registered output and a purely combinational one. With the register, the latency is one clock and an active-low synchronous reset clears the output.

Top module: `bitonic_sorter`

## Requirements
- R1: With the default registered output, the output words are non-decreasing from word 0 (bits [W-1:0]) up to word 2^N-1.
- R2: The output holds the same multiset of values as the input: duplicates are kept and no value is lost or invented.
- R3: Output word 0 equals the smallest input word, and output word 2^N-1 equals the largest input word.
- R4: Every input whose words each hold 0 or 1 (all 2^(2^N) such patterns) is sorted correctly.
- R5: With the registered output, a vector applied before a rising clock edge appears on out_data just after that edge, and out_data keeps its previous value until that edge.
- R6: While rst_n is low at a rising edge, out_data becomes all zeros, whatever in_data holds.
- R7: Input that is already ascending, input that is descending, and input with every word equal are all returned in ascending order, with the correct values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 2^N*W | Unsorted words; word j at bits [j*W +: W] |
| out_data | output | 2^N*W | Sorted words, smallest in word 0 |

## Verification
The checker assumes that in_data is stable and fully defined at each rising edge while rst_n is high. The property checks on sum, minimum and maximum compare the output with the input that was sampled one edge earlier. They start to apply only one edge after reset is released. The bench respects these assumptions: it changes in_data only on falling edges, never drives X or Z onto it, and holds reset low from time zero until after several edges.

// File: rtl/sort_pkg.sv
// Shared helpers for the sorting network.
// Assumes orders stay small enough that a lane count fits in 32 bits.
package sort_pkg;

    // Largest supported network order
    localparam int unsigned MAX_ORDER = 5;

    // Number of words on a bus of the given order
    function automatic int unsigned lane_count(input int unsigned order);
        return 32'd1 << order;
    endfunction

    // Width of a sum of 2^order words of w bits without overflow
    function automatic int unsigned sum_width(input int unsigned order, input int unsigned w);
        return w + order;
    endfunction

endpackage

// File: rtl/cmp_swap.sv
// Two-word compare-exchange cell.
// DESC=0 sends the smaller word to x_o and the larger to y_o; DESC=1 does the reverse.
// Equal words are never exchanged. Purely combinational.
module cmp_swap #(
    parameter int unsigned W    = 8,
    parameter bit          DESC = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);

    logic swap;

    // Decide on an exchange; a strict compare keeps equal words in place
    always_comb begin
        swap = DESC ? (a_i < b_i) : (a_i > b_i);
        x_o  = swap ? b_i : a_i;
        y_o  = swap ? a_i : b_i;
    end

endmodule

// File: rtl/ilv_stage.sv
// Order-K interleave of the compare-exchange cell over 2^(K+1) words.
// Order 0 is one cell. Order K separates even and odd words, applies order K-1
// to each group, and puts the groups back into alternating positions. The net
// effect compares word i with word i+2^K. Assumes K is at most MAX_ORDER.
module ilv_stage #(
    parameter int unsigned K    = 1,
    parameter int unsigned W    = 8,
    parameter bit          DESC = 1'b0
) (
    input  logic [(2<<K)*W-1:0] d_i,
    output logic [(2<<K)*W-1:0] d_o
);

    localparam int unsigned LW = 2 << K;
    localparam int unsigned HW = LW / 2;

    if (K == 0) begin : g_cell
        cmp_swap #(.W(W), .DESC(DESC)) u_cell (
            .a_i(d_i[W-1:0]),
            .b_i(d_i[2*W-1:W]),
            .x_o(d_o[W-1:0]),
            .y_o(d_o[2*W-1:W])
        );
    end else begin : g_wrap
        logic [HW*W-1:0] ev_in, od_in, ev_out, od_out;

        // Separate the bus: even positions to one group, odd positions to the other
        always_comb begin
            for (int j = 0; j < HW; j++) begin
                ev_in[j*W +: W] = d_i[(2*j)*W +: W];
                od_in[j*W +: W] = d_i[(2*j+1)*W +: W];
            end
        end

        ilv_stage #(.K(K-1), .W(W), .DESC(DESC)) u_even (.d_i(ev_in), .d_o(ev_out));
        ilv_stage #(.K(K-1), .W(W), .DESC(DESC)) u_odd  (.d_i(od_in), .d_o(od_out));

        // Put the two groups back into alternating positions
        always_comb begin
            for (int j = 0; j < HW; j++) begin
                d_o[(2*j)*W +: W]   = ev_out[j*W +: W];
                d_o[(2*j+1)*W +: W] = od_out[j*W +: W];
            end
        end
    end

endmodule

// File: rtl/bfly_merge.sv
// Order-K butterfly merger over 2^K words.
// Order 0 passes its input through. Order K applies an order K-1 interleave and
// then two order K-1 butterflies, one on each half of the bus.
// Assumes a bitonic input; the output is then monotonic in the DESC direction.
module bfly_merge #(
    parameter int unsigned K    = 3,
    parameter int unsigned W    = 8,
    parameter bit          DESC = 1'b0
) (
    input  logic [(1<<K)*W-1:0] d_i,
    output logic [(1<<K)*W-1:0] d_o
);

    localparam int unsigned LW = 1 << K;
    localparam int unsigned HB = (LW / 2) * W;

    if (K == 0) begin : g_wire
        assign d_o = d_i;
    end else begin : g_rec
        logic [LW*W-1:0] mid;

        ilv_stage #(.K(K-1), .W(W), .DESC(DESC)) u_ilv (.d_i(d_i), .d_o(mid));

        bfly_merge #(.K(K-1), .W(W), .DESC(DESC)) u_lo (
            .d_i(mid[HB-1:0]),
            .d_o(d_o[HB-1:0])
        );
        bfly_merge #(.K(K-1), .W(W), .DESC(DESC)) u_hi (
            .d_i(mid[LW*W-1:HB]),
            .d_o(d_o[LW*W-1:HB])
        );
    end

endmodule

// File: rtl/sort_net.sv
// Order-K full bitonic sorter over 2^K words.
// It sorts the lower half ascending and the upper half descending, then merges the
// resulting bitonic sequence in the DESC direction. Purely combinational; any input is accepted.
module sort_net #(
    parameter int unsigned K    = 3,
    parameter int unsigned W    = 8,
    parameter bit          DESC = 1'b0
) (
    input  logic [(1<<K)*W-1:0] d_i,
    output logic [(1<<K)*W-1:0] d_o
);

    localparam int unsigned LW = 1 << K;
    localparam int unsigned HB = (LW / 2) * W;

    if (K == 0) begin : g_wire
        assign d_o = d_i;
    end else begin : g_rec
        logic [LW*W-1:0] halves;

        sort_net #(.K(K-1), .W(W), .DESC(1'b0)) u_up (
            .d_i(d_i[HB-1:0]),
            .d_o(halves[HB-1:0])
        );
        sort_net #(.K(K-1), .W(W), .DESC(1'b1)) u_down (
            .d_i(d_i[LW*W-1:HB]),
            .d_o(halves[LW*W-1:HB])
        );

        bfly_merge #(.K(K), .W(W), .DESC(DESC)) u_merge (.d_i(halves), .d_o(d_o));
    end

endmodule

// File: rtl/bitonic_sorter.sv
// Top level: sorts 2^N unsigned W-bit words, smallest in word 0.
// REG_OUT=1 adds one output register with synchronous active-low reset.
// REG_OUT=0 leaves the path combinational, and clk/rst_n are then unused.
// Assumes 1 <= N <= MAX_ORDER.
module bitonic_sorter #(
    parameter int unsigned N       = 3,
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [sort_pkg::lane_count(N)*W-1:0]   in_data,
    output logic [sort_pkg::lane_count(N)*W-1:0]   out_data
);

    localparam int unsigned LANES = sort_pkg::lane_count(N);
    localparam int unsigned VW    = LANES * W;

    logic [VW-1:0] sorted;

    sort_net #(.K(N), .W(W), .DESC(1'b0)) u_net (.d_i(in_data), .d_o(sorted));

    if (REG_OUT) begin : g_reg
        // Capture the network result; reset clears it
        always_ff @(posedge clk) begin
            if (!rst_n) out_data <= '0;
            else        out_data <= sorted;
        end
    end else begin : g_comb
        assign out_data = sorted;
    end

endmodule

// File: rtl/sorter_chk.sv
// Property checker for bitonic_sorter, attached by bind.
// Assumes in_data is defined at every rising edge while rst_n is high.
module sorter_chk #(
    parameter int unsigned N       = 3,
    parameter int unsigned W       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [sort_pkg::lane_count(N)*W-1:0] in_data,
    input logic [sort_pkg::lane_count(N)*W-1:0] out_data
);

    localparam int unsigned LANES = sort_pkg::lane_count(N);
    localparam int unsigned SW    = sort_pkg::sum_width(N, W);

    logic          ordered;
    logic [SW-1:0] in_sum, out_sum;
    logic [W-1:0]  in_min, in_max;
    logic          primed;

    // Summaries of the input and output buses
    always_comb begin
        ordered = 1'b1;
        in_sum  = '0;
        out_sum = '0;
        in_min  = in_data[W-1:0];
        in_max  = in_data[W-1:0];
        for (int j = 0; j < LANES; j++) begin
            in_sum  = in_sum + SW'(in_data[j*W +: W]);
            out_sum = out_sum + SW'(out_data[j*W +: W]);
            if (in_data[j*W +: W] < in_min) in_min = in_data[j*W +: W];
            if (in_data[j*W +: W] > in_max) in_max = in_data[j*W +: W];
            if (j > 0 && out_data[j*W +: W] < out_data[(j-1)*W +: W]) ordered = 1'b0;
        end
    end

    // Marks that one full edge has passed since reset was released
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R1: output never decreases from word 0 upward
    assert_sorted_R1: assert property (@(posedge clk) disable iff (!rst_n) ordered);

    if (REG_OUT) begin : g_seq
        // R2: sum is preserved (multiset check)
        assert_sum_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> out_sum == $past(in_sum));
        // R3: extremes land in the end words
        assert_min_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> out_data[W-1:0] == $past(in_min));
        assert_max_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> out_data[LANES*W-1 -: W] == $past(in_max));
        // R6: a reset edge clears the output
        assert_reset_clear_R6: assert property (@(posedge clk)
            !rst_n |=> out_data == '0);
    end else begin : g_comb
        assert_sum_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_sum == in_sum);
        assert_min_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_data[W-1:0] == in_min);
        assert_max_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_data[LANES*W-1 -: W] == in_max);
    end

endmodule

bind bitonic_sorter sorter_chk #(.N(N), .W(W), .REG_OUT(REG_OUT)) u_sorter_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_data(in_data),
    .out_data(out_data)
);

// File: tb/test_bitonic_sorter.sv
// Scoreboard bench: the driver queues expected vectors, the monitor checks them after each edge.
module test_bitonic_sorter;

    localparam int unsigned N     = 3;
    localparam int unsigned W     = 8;
    localparam int unsigned LANES = 1 << N;
    localparam int unsigned VW    = LANES * W;

    typedef struct {
        logic [VW-1:0] exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] in_data = '0;
    logic [VW-1:0] out_data;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;

    bitonic_sorter #(.N(N), .W(W), .REG_OUT(1'b1)) i_bitonic_sorter (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .out_data(out_data)
    );

    always #5 clk = ~clk;

    // Reference: insertion sort of the words, ascending from word 0
    function automatic logic [VW-1:0] ref_sort(input logic [VW-1:0] v);
        logic [W-1:0] a [LANES];
        logic [W-1:0] t;
        logic [VW-1:0] r;
        for (int j = 0; j < LANES; j++) a[j] = v[j*W +: W];
        for (int i = 1; i < LANES; i++) begin
            for (int j = i; j > 0; j--) begin
                if (a[j-1] > a[j]) begin
                    t = a[j]; a[j] = a[j-1]; a[j-1] = t;
                end
            end
        end
        for (int j = 0; j < LANES; j++) r[j*W +: W] = a[j];
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply a vector on a falling edge and queue its expected result
    task automatic drive(input logic [VW-1:0] v, input string tag);
        item_t it;
        @(negedge clk);
        in_data = v;
        it.exp = ref_sort(v);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: just after each rising edge, compare against the oldest queued item
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(out_data === it.exp, it.tag, out_data, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] v;
        logic [VW-1:0] prev;
        // R6: output is zero while reset is held
        in_data = {VW{1'b1}};
        repeat (3) @(negedge clk);
        check(out_data === '0, "R6 reset state", out_data, '0);
        rst_n = 1'b1;

        // R4: every 0/1 pattern
        for (int p = 0; p < (1 << LANES); p++) begin
            for (int j = 0; j < LANES; j++) v[j*W +: W] = W'(p[j]);
            drive(v, "R4 zero-one pattern");
        end

        // R7: ascending, descending and constant inputs
        for (int j = 0; j < LANES; j++) v[j*W +: W] = W'(j * 7 + 1);
        drive(v, "R7 ascending input");
        for (int j = 0; j < LANES; j++) v[j*W +: W] = W'(250 - j * 9);
        drive(v, "R7 descending input");
        drive({LANES{8'h5A}}, "R7 all equal");
        drive({LANES{8'hFF}}, "R3 all max");
        drive('0, "R3 all zero");

        // R1, R2, R3: random words, full range and dense duplicates
        for (int n = 0; n < 200; n++) begin
            for (int j = 0; j < LANES; j++) v[j*W +: W] = W'($urandom);
            drive(v, "R1 R3 random");
        end
        for (int n = 0; n < 100; n++) begin
            for (int j = 0; j < LANES; j++) v[j*W +: W] = W'($urandom & 3);
            drive(v, "R2 duplicates");
        end

        // R5: output holds until the next edge, then shows the new result
        for (int j = 0; j < LANES; j++) v[j*W +: W] = W'(LANES - j);
        drive(v, "R5 first vector");
        prev = ref_sort(v);
        for (int j = 0; j < LANES; j++) v[j*W +: W] = W'(200 + j);
        drive(v, "R5 new vector after edge");
        #1;
        check(out_data === prev, "R5 hold before edge", out_data, prev);

        // R6: reset mid-run clears output despite nonzero input
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        in_data = {LANES{8'hC3}};
        @(negedge clk);
        check(out_data === '0, "R6 reset mid-run", out_data, '0);
        rst_n = 1'b1;
        drive({LANES{8'h11}} ^ {{(VW-8){1'b0}}, 8'hF0}, "R2 after reset");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R5 scoreboard drained", VW'(q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule